// File: doc/BRIEF.md
# Burst Address Generator

This block supplies the word address to a synchronous burst memory array. On a rising clock edge where either burst-start strobe is low, it takes the whole external address as the base of a new burst and clears a two-bit burst counter. On later edges where the advance strobe is low, only the counter moves. The output keeps the base's upper bits. Its two low bits come from the base low bits combined with the counter. A burst therefore visits four word addresses inside one aligned group of four and then wraps within that group.

Two independent strobes can start a burst, one for the processor side and one for the cache-controller side. Either of them alone, or both together, causes the same load. A static mode pin picks the low-bit order. In linear order the low bits count up modulo 4 from the loaded value. In interleaved order they are the loaded bits XOR the counter. The mode pin is not registered and acts on the output at once. The address and all strobes are sampled only at the rising clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low and after it is released, before any start, addr_q is all zeros.
- R2: When proc_start_n is 0 at a rising edge, addr_q after that edge equals the addr_d value sampled at that edge, with counter zero.
- R3: When ctrl_start_n is 0 at a rising edge, the load is the same as in R2. When both strobes are 0 together, a single load takes place.
- R4: A start strobe overrides adv_n: a start with adv_n 0 at the same edge loads the address and does not step the counter.
- R5: With seq_il = 0 (linear), each edge with adv_n 0 and no start makes addr_q[1:0] = base[1:0] + k mod 4, where k is the number of advances since the load, mod 4.
- R6: With seq_il = 1 (interleaved), addr_q[1:0] = base[1:0] XOR k, with k as in R5.
- R7: addr_q[ADDR_W-1:2] stays at the loaded upper bits during the whole burst. After the fourth advance the low bits return to their loaded value, and nothing carries into the upper bits.
- R8: At an edge with no start and adv_n 1, addr_q does not change. addr_d is ignored at such an edge.
- R9: seq_il acts combinationally: changing it between edges changes addr_q[1:0] at once, and the counter is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_start_n | input | 1 | Processor-side burst start, active low |
| ctrl_start_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| seq_il | input | 1 | Burst order: 0 linear, 1 interleaved (unregistered) |
| addr_d | input | ADDR_W | External word address |
| addr_q | output | ADDR_W | Current array word address |

## Verification
The bench builds the block with ADDR_W = 6. At that width every one of the 64 base addresses can be loaded. For each base it runs a full four-step burst plus the wrap step, in both orders and with each start strobe. Every base thus reaches every low-bit start value under every upper-bit pattern, which makes an incorrect carry or a wrong sequence visible. Further sequences check the case where both strobes are low at one edge, a start together with an advance, idle edges that present a different addr_d, and a change of the mode pin in the middle of a burst.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              adv_n,
  input  logic              seq_il,
  input  logic [ADDR_W-1:0] addr_d,
  output logic [ADDR_W-1:0] addr_q
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              start;

  assign start = ~proc_start_n | ~ctrl_start_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      base_q <= addr_d;
      cnt_q  <= '0;
    end else if (!adv_n) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign addr_q = {base_q[ADDR_W-1:2],
                   seq_il ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q)};

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (base_q == $past(addr_d)) && (cnt_q == 2'd0));

  a_r4_start_over_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !adv_n) |=> cnt_q == 2'd0);

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !adv_n) |=> cnt_q == $past(cnt_q) + 2'd1);

  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(addr_q[ADDR_W-1:2]));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && adv_n) |=> ($stable(cnt_q) && $stable(base_q)));

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int W = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic proc_start_n = 1, ctrl_start_n = 1, adv_n = 1, seq_il = 0;
  logic [W-1:0] addr_d = '0;
  logic [W-1:0] addr_q;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .proc_start_n(proc_start_n),
    .ctrl_start_n(ctrl_start_n), .adv_n(adv_n), .seq_il(seq_il),
    .addr_d(addr_d), .addr_q(addr_q));

  function automatic logic [W-1:0] expect_addr(logic [W-1:0] b, logic il, int k);
    logic [1:0] kk = 2'(k);
    return {b[W-1:2], il ? (b[1:0] ^ kk) : (b[1:0] + kk)};
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if (addr_q !== exp) begin
      fails++;
      $display("FAIL %s: addr_q=%0h expected=%0h", req, addr_q, exp);
    end
  endtask

  task automatic step(logic ps, logic cs, logic adv, logic [W-1:0] a);
    proc_start_n = ps; ctrl_start_n = cs; adv_n = adv; addr_d = a;
    @(negedge clk);
    proc_start_n = 1; ctrl_start_n = 1; adv_n = 1;
  endtask

  initial begin
    @(negedge clk);
    check("R1", '0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", '0);

    for (int il = 0; il < 2; il++) begin
      seq_il = il[0];
      for (int src = 0; src < 2; src++) begin
        for (int b = 0; b < (1 << W); b++) begin
          step(src != 0, src == 0, 1'b1, W'(b));
          check(src == 0 ? "R2" : "R3", W'(b));
          for (int k = 1; k <= 5; k++) begin
            step(1'b1, 1'b1, 1'b0, W'(~b));
            check(il != 0 ? "R6" : "R5", expect_addr(W'(b), il[0], k));
          end
          check("R7", expect_addr(W'(b), il[0], 1));
        end
      end
    end

    seq_il = 0;
    step(1'b0, 1'b0, 1'b1, 6'h2d);
    check("R3", 6'h2d);
    step(1'b1, 1'b1, 1'b0, 6'h00);
    check("R5", 6'h2e);
    step(1'b0, 1'b1, 1'b0, 6'h13);
    check("R4", 6'h13);
    step(1'b1, 1'b1, 1'b0, 6'h00);
    check("R4", 6'h10);
    step(1'b1, 1'b1, 1'b1, 6'h3f);
    check("R8", 6'h10);
    step(1'b1, 1'b1, 1'b1, 6'h2a);
    check("R8", 6'h10);
    seq_il = 1;
    #1;
    check("R9", 6'h12);
    step(1'b1, 1'b1, 1'b0, 6'h00);
    check("R9", 6'h11);
    seq_il = 0;
    #1;
    check("R9", 6'h11);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule